// File: doc/BRIEF.md
# Programmable Video Sync Window Generator

The block produces a single user-shaped timing strobe for a raster video output. An external raster timing core supplies the running pixel count, the line count and a field flag. The block holds a horizontal window (start and stop pixel) and a vertical window (start and stop line). On every pixel clock it tests both counters against their windows and merges the two results with a selectable logical operator. A polarity control then sets the final output level, and the result is registered.

Settings are loaded through a plain write port. Each write lands in a staging copy. The copy the comparators use is refreshed only on a cycle where the pixel count is zero, so a line that is already being drawn never changes shape part way through. For interlaced rasters the vertical window is given in first-field line numbers. Second-field lines are shifted down by a fixed line offset so that they fall into the same window.

Top module: `sync_window_gen`

## Requirements
- R1: The horizontal window is active while start <= pixel count < stop, with 16-bit start (address 0) and stop (address 1) values.
- R2: The vertical window is active while start <= effective line < stop, with 15-bit start (address 2) and stop (address 3) values. Bit 15 of a write to either address is dropped.
- R3: With `field_i` = 1, the effective line is the line count minus LINE_OFS (263 by default), and a line count below LINE_OFS is never inside the vertical window. With `field_i` = 0, the effective line is the line count itself.
- R4: The control register is at address 4, with bit 3 polarity, bit 2 AND select, bit 1 OR select and bit 0 XOR select. With AND set, the combined signal is horizontal AND vertical, and the OR and XOR selects have no effect.
- R5: With AND clear and OR set, the combined signal is horizontal OR vertical, and the XOR select has no effect.
- R6: With only XOR set, the combined signal is active when exactly one window is active.
- R7: With none of the three operator selects set, the combined signal follows the horizontal window alone.
- R8: With polarity 1, the output is the inverse of the combined signal (active-low). With polarity 0, the output equals the combined signal (active-high).
- R9: Bits 15 to 4 of a control register write have no effect.
- R10: The output is registered and reflects the counter inputs present one clock earlier.
- R11: A write first affects the output on a cycle whose pixel count input is 0, later than the write. Before that cycle the output keeps following the previous settings.
- R12: Reset sets all window limits and operator selects to 0 and polarity to 1. The output is driven high during reset and stays high afterwards until new settings are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_cnt_i | input | HW (16) | Running pixel count in the line |
| line_cnt_i | input | VW (15) | Running line count in the frame |
| field_i | input | 1 | Field flag: 0 first field, 1 second field |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (3) | Register address (0..4) |
| wr_data_i | input | DW (16) | Register write data |
| strobe_o | output | 1 | Registered user timing strobe |

## Verification
The bench builds the block with its default parameters: 16-bit pixel limits, 15-bit line limits, interlace mapping enabled and a second-field offset of 263. This lets a single vector table reach every operator priority case and both polarities. It also reaches both edges of each window and the second-field remapping, including second-field line counts below the offset. Because the bench writes a full 16-bit data word, it can place junk in the reserved upper bits of every control write and set bit 15 of the vertical start write. The directed part covers the reset level, the single-cycle output lag and the deferral of a mid-line write until the next pixel-zero cycle.

// File: rtl/swg_pkg.sv
package swg_pkg;

   // Register addresses on the write port
   localparam int unsigned ADR_H_LO = 0;
   localparam int unsigned ADR_H_HI = 1;
   localparam int unsigned ADR_V_LO = 2;
   localparam int unsigned ADR_V_HI = 3;
   localparam int unsigned ADR_CTL  = 4;

   // Control word layout; bit order is the decode order
   typedef struct packed {
      logic pol;
      logic and_sel;
      logic or_sel;
      logic xor_sel;
   } swg_ctl_t;

   localparam int unsigned CTL_BITS = $bits(swg_ctl_t);
   localparam swg_ctl_t CTL_RST = '{pol: 1'b1, and_sel: 1'b0, or_sel: 1'b0, xor_sel: 1'b0};

   typedef enum logic [1:0] {
      OP_H_ONLY = 2'd0,
      OP_XOR    = 2'd1,
      OP_OR     = 2'd2,
      OP_AND    = 2'd3
   } swg_op_e;

   // Priority pick: AND over OR over XOR, else horizontal alone
   function automatic swg_op_e swg_pick_op(swg_ctl_t c);
      if (c.and_sel)      return OP_AND;
      else if (c.or_sel)  return OP_OR;
      else if (c.xor_sel) return OP_XOR;
      else                return OP_H_ONLY;
   endfunction

endpackage

// File: rtl/swg_shadow.sv
// Staged setting with a line-boundary transfer into the working copy.
module swg_shadow #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [W-1:0] d_i,
   input  logic         load_i,
   output logic [W-1:0] use_o,
   output logic [W-1:0] act_o
);

   logic [W-1:0] stg_q;
   logic [W-1:0] act_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= RST_VAL;
      end else if (wr_i) begin
         stg_q <= d_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= RST_VAL;
      end else if (load_i) begin
         act_q <= stg_q;
      end
   end

   // On the boundary cycle the staged value is already in force
   assign use_o = load_i ? stg_q : act_q;
   assign act_o = act_q;

endmodule

// File: rtl/swg_cfg_regs.sv
module swg_cfg_regs
   import swg_pkg::*;
#(
   parameter int unsigned HW = 16,
   parameter int unsigned VW = 15,
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 3,
   localparam int unsigned ACT_W = 2*HW + 2*VW + CTL_BITS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [DW-1:0]    wr_data_i,
   input  logic             line_start_i,
   output logic [HW-1:0]    h_lo_o,
   output logic [HW-1:0]    h_hi_o,
   output logic [VW-1:0]    v_lo_o,
   output logic [VW-1:0]    v_hi_o,
   output swg_ctl_t         ctl_o,
   output logic [ACT_W-1:0] act_all_o
);

   localparam int unsigned NREG = 5;

   logic [NREG-1:0] sel;
   logic [HW-1:0]   h_lo_a, h_hi_a;
   logic [VW-1:0]   v_lo_a, v_hi_a;
   logic [CTL_BITS-1:0] ctl_use, ctl_a;

   // One-hot address decode
   always_comb begin
      sel = '0;
      if (wr_en_i) begin
         if (wr_addr_i == AW'(ADR_H_LO)) sel[0] = 1'b1;
         if (wr_addr_i == AW'(ADR_H_HI)) sel[1] = 1'b1;
         if (wr_addr_i == AW'(ADR_V_LO)) sel[2] = 1'b1;
         if (wr_addr_i == AW'(ADR_V_HI)) sel[3] = 1'b1;
         if (wr_addr_i == AW'(ADR_CTL))  sel[4] = 1'b1;
      end
   end

   // Upper data bits beyond each field are reserved and dropped
   swg_shadow #(.W(HW), .RST_VAL('0)) i_h_lo (
      .clk_i, .rst_ni, .wr_i(sel[0]), .d_i(wr_data_i[HW-1:0]),
      .load_i(line_start_i), .use_o(h_lo_o), .act_o(h_lo_a));

   swg_shadow #(.W(HW), .RST_VAL('0)) i_h_hi (
      .clk_i, .rst_ni, .wr_i(sel[1]), .d_i(wr_data_i[HW-1:0]),
      .load_i(line_start_i), .use_o(h_hi_o), .act_o(h_hi_a));

   swg_shadow #(.W(VW), .RST_VAL('0)) i_v_lo (
      .clk_i, .rst_ni, .wr_i(sel[2]), .d_i(wr_data_i[VW-1:0]),
      .load_i(line_start_i), .use_o(v_lo_o), .act_o(v_lo_a));

   swg_shadow #(.W(VW), .RST_VAL('0)) i_v_hi (
      .clk_i, .rst_ni, .wr_i(sel[3]), .d_i(wr_data_i[VW-1:0]),
      .load_i(line_start_i), .use_o(v_hi_o), .act_o(v_hi_a));

   swg_shadow #(.W(CTL_BITS), .RST_VAL(CTL_RST)) i_ctl (
      .clk_i, .rst_ni, .wr_i(sel[4]), .d_i(wr_data_i[CTL_BITS-1:0]),
      .load_i(line_start_i), .use_o(ctl_use), .act_o(ctl_a));

   assign ctl_o     = swg_ctl_t'(ctl_use);
   assign act_all_o = {h_lo_a, h_hi_a, v_lo_a, v_hi_a, ctl_a};

endmodule

// File: rtl/swg_window.sv
// Half-open range test: lo <= pos < hi
module swg_window #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] pos_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic         hit_o
);

   logic ge_lo;
   logic lt_hi;

   assign ge_lo = (pos_i >= lo_i);
   assign lt_hi = (pos_i <  hi_i);
   assign hit_o = ge_lo & lt_hi;

endmodule

// File: rtl/swg_combine.sv
module swg_combine
   import swg_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     h_hit_i,
   input  logic     v_hit_i,
   input  swg_ctl_t ctl_i,
   output logic     strobe_o
);

   swg_op_e op;
   logic    merged;
   logic    strobe_q;

   assign op = swg_pick_op(ctl_i);

   always_comb begin
      unique case (op)
         OP_AND:  merged = h_hit_i & v_hit_i;
         OP_OR:   merged = h_hit_i | v_hit_i;
         OP_XOR:  merged = h_hit_i ^ v_hit_i;
         default: merged = h_hit_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         strobe_q <= CTL_RST.pol;
      end else begin
         strobe_q <= merged ^ ctl_i.pol;
      end
   end

   assign strobe_o = strobe_q;

endmodule

// File: rtl/sync_window_gen.sv
module sync_window_gen
   import swg_pkg::*;
#(
   parameter int unsigned HW        = 16,
   parameter int unsigned VW        = 15,
   parameter int unsigned DW        = 16,
   parameter int unsigned AW        = 3,
   parameter bit          INTERLACE = 1'b1,
   parameter int unsigned LINE_OFS  = 263
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [HW-1:0] pix_cnt_i,
   input  logic [VW-1:0] line_cnt_i,
   input  logic          field_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          strobe_o
);

   localparam int unsigned ACT_W = 2*HW + 2*VW + CTL_BITS;

   // Elaboration-time parameter checks
   if (HW < 2 || HW > DW) begin : g_bad_hw
      $error("sync_window_gen: HW must be in 2..DW");
   end
   if (VW < 2 || VW + 1 > DW) begin : g_bad_vw
      $error("sync_window_gen: VW must be in 2..DW-1");
   end
   if (CTL_BITS > DW) begin : g_bad_dw
      $error("sync_window_gen: DW too narrow for control word");
   end
   if ((1 << AW) <= ADR_CTL) begin : g_bad_aw
      $error("sync_window_gen: AW too narrow for register map");
   end
   if (INTERLACE && (LINE_OFS >= (1 << VW))) begin : g_bad_ofs
      $error("sync_window_gen: LINE_OFS exceeds line range");
   end

   logic            line_start;
   logic [HW-1:0]   h_lo, h_hi;
   logic [VW-1:0]   v_lo, v_hi;
   swg_ctl_t        ctl;
   logic [ACT_W-1:0] act_all;
   logic [VW-1:0]   eff_line;
   logic            h_hit, v_hit;

   assign line_start = (pix_cnt_i == '0);

   swg_cfg_regs #(.HW(HW), .VW(VW), .DW(DW), .AW(AW)) i_cfg (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .line_start_i(line_start),
      .h_lo_o(h_lo), .h_hi_o(h_hi), .v_lo_o(v_lo), .v_hi_o(v_hi),
      .ctl_o(ctl), .act_all_o(act_all));

   // Second-field line numbers fold onto first-field numbering
   if (INTERLACE) begin : g_ilace
      localparam logic [VW-1:0] OFS_V = VW'(LINE_OFS);
      always_comb begin
         if (!field_i)               eff_line = line_cnt_i;
         else if (line_cnt_i >= OFS_V) eff_line = line_cnt_i - OFS_V;
         else                        eff_line = '1;  // never inside a window
      end
   end else begin : g_prog
      logic unused_field;
      assign unused_field = field_i;
      assign eff_line     = line_cnt_i;
   end

   swg_window #(.W(HW)) i_h_win (
      .pos_i(pix_cnt_i), .lo_i(h_lo), .hi_i(h_hi), .hit_o(h_hit));

   swg_window #(.W(VW)) i_v_win (
      .pos_i(eff_line), .lo_i(v_lo), .hi_i(v_hi), .hit_o(v_hit));

   swg_combine i_comb (
      .clk_i, .rst_ni, .h_hit_i(h_hit), .v_hit_i(v_hit),
      .ctl_i(ctl), .strobe_o(strobe_o));

endmodule

// File: rtl/sync_window_gen_chk.sv
module sync_window_gen_chk
   import swg_pkg::*;
#(
   parameter int unsigned ACT_W = 66
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             line_start,
   input logic             h_hit,
   input logic             v_hit,
   input swg_ctl_t         ctl,
   input logic [ACT_W-1:0] act_all,
   input logic             strobe_o
);

   logic armed;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   AST_AND_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && ctl.and_sel) |=> ((strobe_o ^ $past(ctl.pol)) == $past(h_hit & v_hit))); // R4

   AST_OR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !ctl.and_sel && ctl.or_sel) |=> ((strobe_o ^ $past(ctl.pol)) == $past(h_hit | v_hit))); // R5

   AST_XOR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !ctl.and_sel && !ctl.or_sel && ctl.xor_sel) |=> ((strobe_o ^ $past(ctl.pol)) == $past(h_hit ^ v_hit))); // R6

   AST_H_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !ctl.and_sel && !ctl.or_sel && !ctl.xor_sel) |=> ((strobe_o ^ $past(ctl.pol)) == $past(h_hit))); // R7

   AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !line_start) |=> $stable(act_all)); // R11

   AST_RESET_IDLE: assert property (@(posedge clk_i)
      !rst_ni |=> strobe_o); // R12

endmodule

bind sync_window_gen sync_window_gen_chk #(.ACT_W(ACT_W)) i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .line_start(line_start),
   .h_hit(h_hit), .v_hit(v_hit), .ctl(ctl), .act_all(act_all),
   .strobe_o(strobe_o));

// File: tb/test_sync_window_gen.sv
`timescale 1ns/1ps
module test_sync_window_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pix = '0;
   logic [14:0] line = '0;
   logic        fld = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        strobe;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sync_window_gen i_sync_window_gen (
      .clk_i(clk), .rst_ni(rst_n), .pix_cnt_i(pix), .line_cnt_i(line),
      .field_i(fld), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .strobe_o(strobe));

   // {ctl[3:0] = pol,and,or,xor ; pix ; line ; field ; expected strobe}
   // Windows: pixels 10..19, lines 5..7
   localparam int NV = 24;
   localparam logic [36:0] VEC [NV] = '{
      {4'h4, 16'd15, 15'd6,   1'b0, 1'b1},  // R4 both active
      {4'h4, 16'd15, 15'd9,   1'b0, 1'b0},  // R4 h only
      {4'h7, 16'd15, 15'd9,   1'b0, 1'b0},  // R4 AND wins over OR/XOR
      {4'h7, 16'd15, 15'd6,   1'b0, 1'b1},  // R4
      {4'h2, 16'd25, 15'd6,   1'b0, 1'b1},  // R5 v only
      {4'h2, 16'd25, 15'd9,   1'b0, 1'b0},  // R5 neither
      {4'h3, 16'd15, 15'd6,   1'b0, 1'b1},  // R5 XOR ignored
      {4'h1, 16'd15, 15'd6,   1'b0, 1'b0},  // R6 both
      {4'h1, 16'd15, 15'd9,   1'b0, 1'b1},  // R6 h only
      {4'h1, 16'd25, 15'd6,   1'b0, 1'b1},  // R6 v only
      {4'h1, 16'd25, 15'd9,   1'b0, 1'b0},  // R6 neither
      {4'h0, 16'd15, 15'd9,   1'b0, 1'b1},  // R7 h alone
      {4'h0, 16'd25, 15'd6,   1'b0, 1'b0},  // R7 v ignored
      {4'hC, 16'd15, 15'd6,   1'b0, 1'b0},  // R8 active-low active
      {4'hC, 16'd25, 15'd6,   1'b0, 1'b1},  // R8 active-low idle
      {4'h4, 16'd10, 15'd5,   1'b0, 1'b1},  // R1 R2 start inclusive
      {4'h4, 16'd20, 15'd6,   1'b0, 1'b0},  // R1 stop exclusive
      {4'h4, 16'd19, 15'd7,   1'b0, 1'b1},  // R1 R2 last inside
      {4'h4, 16'd15, 15'd8,   1'b0, 1'b0},  // R2 stop exclusive
      {4'h4, 16'd9,  15'd6,   1'b0, 1'b0},  // R1 below start
      {4'h4, 16'd15, 15'd269, 1'b1, 1'b1},  // R3 269-263=6
      {4'h4, 16'd15, 15'd6,   1'b1, 1'b0},  // R3 below offset
      {4'h4, 16'd15, 15'd271, 1'b1, 1'b0},  // R3 271-263=8
      {4'h4, 16'd15, 15'd269, 1'b0, 1'b0}   // R3 first field unmapped
   };

   task automatic check(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: strobe=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic step(input logic [15:0] p, input logic [14:0] l, input logic f);
      pix = p; line = l; fld = f;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset level", strobe, 1'b1);
      rst_n = 1'b1;
      step(16'd5, 15'd0, 1'b0);
      step(16'd0, 15'd0, 1'b0);
      step(16'd15, 15'd6, 1'b0);
      check("R12 idle after reset", strobe, 1'b1);

      // Program windows; bit 15 of vertical start is reserved (R2)
      wr(3'd0, 16'd10);
      wr(3'd1, 16'd20);
      wr(3'd2, 16'h8005);
      wr(3'd3, 16'd8);

      // Table walk; reserved control bits carry junk (R9)
      for (int i = 0; i < NV; i++) begin
         logic [36:0] v;
         v = VEC[i];
         wr(3'd4, {12'hA5C, v[36:33]});
         step(16'd0, 15'd0, 1'b0);
         step(v[32:17], v[16:2], v[1]);
         check($sformatf("R9 vector %0d", i), strobe, v[0]);
      end

      // R10: one-cycle lag (AND, active-high in force)
      wr(3'd4, 16'h0004);
      step(16'd0, 15'd0, 1'b0);
      step(16'd25, 15'd6, 1'b0);
      check("R10 before", strobe, 1'b0);
      pix = 16'd15;
      #1;
      check("R10 not yet", strobe, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R10 after", strobe, 1'b1);

      // R11: mid-line write deferred to next pixel-zero cycle
      wr(3'd1, 16'd12);
      step(16'd15, 15'd6, 1'b0);
      check("R11 old setting kept", strobe, 1'b1);
      wr(3'd4, 16'hF00C);
      step(16'd15, 15'd6, 1'b0);
      check("R11 old polarity kept", strobe, 1'b1);
      step(16'd0, 15'd0, 1'b0);
      step(16'd15, 15'd6, 1'b0);
      check("R11 new setting at line start", strobe, 1'b1);
      step(16'd11, 15'd6, 1'b0);
      check("R8 R11 active-low inside", strobe, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule